// File: doc/BRIEF.md
# Memory Operation Ordering Fence Unit

This block stands between an in-order issue stage and a memory system that may finish data accesses in any order. Each operation at the head of the issue stream carries a 2-bit kind: plain data, full sync, acquire or release. Every cycle the block decides whether that head operation may go to memory. A sync is a full barrier, which gives weak ordering. An acquire and a release get one-sided ordering, which gives release consistency. An acquire blocks everything after it until it completes, but it does not wait for earlier data. A release waits for everything before it, but later data accesses may pass it.

The block has three pieces of state. A saturating counter holds the number of data accesses in flight. A small tracker records whether a sync or acquire is pending, or whether a release is pending. A one-cycle completion pulse from memory carries a flag that says whether the completed access was a synchronization access or a data access. Readiness comes only from registered state, so a completion frees the stream in the cycle after the pulse.

Top module: `mem_fence_unit`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `op_ready` and `mem_valid` are 0. In the first cycle after reset, with nothing outstanding, `op_ready` is 1 for every kind.
- R2: The in-flight data count rises by one for each issued data access and falls by one for each data completion (`cpl_valid`=1, `cpl_sync`=0). An issue and a completion in the same cycle leave it unchanged.
- R3: When the count reaches its maximum, 2**CNT_W-1 (7 by default), `op_ready` is 0 for data. The count never wraps.
- R4: A sync (kind 01) is ready only when the data count is zero.
- R5: Once a sync or acquire has issued, `op_ready` is 0 for every kind until a synchronization completion (`cpl_valid`=1, `cpl_sync`=1) arrives.
- R6: An acquire (kind 10) is ready while data accesses are still in flight, provided that no synchronization access is pending.
- R7: A release (kind 11) is ready only when the data count is zero and no synchronization access of any kind is pending.
- R8: While a release is pending, data (kind 00) stays ready subject to R3. Sync, acquire and release are not ready until a synchronization completion arrives.
- R9: The kind encoding is 00 data, 01 sync, 10 acquire, 11 release. `mem_valid` equals `op_valid && op_ready`, and `mem_kind` carries `op_kind`.
- R10: Readiness is derived from registered state. A completion in cycle t unblocks the stream in cycle t+1 and not before.
- R11: A data completion while the count is zero, or a synchronization completion while nothing is pending, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Head of the issue stream holds an operation |
| op_kind | input | 2 | Kind of the head operation (00 data, 01 sync, 10 acquire, 11 release) |
| op_ready | output | 1 | Head operation may issue this cycle |
| mem_valid | output | 1 | Operation sent to memory this cycle |
| mem_kind | output | 2 | Kind of the operation sent to memory |
| cpl_valid | input | 1 | One-cycle completion pulse from memory |
| cpl_sync | input | 1 | The completion belongs to a synchronization access |

## Verification
The bench sweeps every in-flight count from 0 to full against each tracker state (idle, full barrier pending, release pending). In each combination it probes readiness for all four kinds.
- A design that let acquire wait for data, or let data pass a pending acquire, would fail the probes with data in flight.
- A counter that wrapped would report data as ready at full.
- A counter that mishandled a simultaneous issue and completion would unblock a sync one completion early or one completion late.
- Stray completions are injected to catch a counter that underflows or a tracker that clears early.
- Completion-to-ready timing is sampled on both sides of the edge to catch a combinational bypass.

// File: rtl/fence_pkg.sv
// Shared types for the memory ordering fence unit.
// Assumes: the kind encoding is fixed by the issue stage and must not change.
package fence_pkg;

    // Operation kind carried with every issued operation
    typedef enum logic [1:0] {
        OP_DATA = 2'b00,
        OP_SYNC = 2'b01,
        OP_ACQ  = 2'b10,
        OP_REL  = 2'b11
    } op_kind_e;

    // Synchronization tracker state
    typedef enum logic [1:0] {
        TRK_IDLE  = 2'b00,
        TRK_FENCE = 2'b01,
        TRK_REL   = 2'b10
    } trk_state_e;

endpackage

// File: rtl/fence_data_ctr.sv
// Saturating counter of data accesses in flight.
// Does: counts issued data accesses up and completed ones down. A
// simultaneous up and down holds the value.
// Assumes: the caller never requests an increment while full. Increments
// at full and decrements at zero are dropped here as a second guard.
module fence_data_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic             empty
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic inc_ok;
    logic dec_ok;

    // Flag the two ends of the counting range
    always_comb begin
        full   = (cnt == CNT_MAX);
        empty  = (cnt == '0);
        inc_ok = inc && !full;
        dec_ok = dec && !empty;
    end

    // Update the count; a simultaneous up and down cancel out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({inc_ok, dec_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !full && !dec) |=> (cnt == $past(cnt) + 1'b1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec && !full && !empty) |=> $stable(cnt)); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (cnt != '0)); // R3
    AST_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !inc) |=> (cnt == '0)); // R11
endmodule

// File: rtl/fence_sync_track.sv
// Tracker for the single outstanding synchronization access.
// Does: after a sync or acquire issues, it holds a full block. After a
// release issues, it holds a partial block. Either block is cleared by a
// synchronization completion.
// Assumes: at most one synchronization access is outstanding at a time.
// The issue gate enforces this.
module fence_sync_track
    import fence_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fence_issue,
    input  logic rel_issue,
    input  logic sync_cpl,
    output logic block_all,
    output logic rel_pending
);
    trk_state_e state;

    // Track which kind of synchronization access is outstanding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TRK_IDLE;
        end else begin
            case (state)
                TRK_IDLE: begin
                    if (fence_issue)    state <= TRK_FENCE;
                    else if (rel_issue) state <= TRK_REL;
                end
                TRK_FENCE: if (sync_cpl) state <= TRK_IDLE;
                TRK_REL:   if (sync_cpl) state <= TRK_IDLE;
                default:   state <= TRK_IDLE;
            endcase
        end
    end

    // Decode the blocking levels for the issue gate
    always_comb begin
        block_all   = (state == TRK_FENCE);
        rel_pending = (state == TRK_REL);
    end

    AST_FENCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (block_all && !sync_cpl) |=> block_all); // R5
    AST_REL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_pending && !sync_cpl) |=> rel_pending); // R8
    AST_IDLE_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!block_all && !rel_pending && !fence_issue && !rel_issue) |=> (!block_all && !rel_pending)); // R11
endmodule

// File: rtl/fence_issue_gate.sv
// Combinational issue decision for the head operation.
// Does: applies the ordering rule for each kind to the registered counter
// and tracker state.
// Assumes: all inputs except op_kind and in_reset come from flops.
module fence_issue_gate
    import fence_pkg::*;
(
    input  logic     in_reset,
    input  op_kind_e kind,
    input  logic     cnt_full,
    input  logic     cnt_empty,
    input  logic     block_all,
    input  logic     rel_pending,
    output logic     ready
);
    // Choose the ordering rule that matches the head operation's kind
    always_comb begin
        ready = 1'b0;
        if (!in_reset && !block_all) begin
            case (kind)
                OP_DATA: ready = !cnt_full;
                OP_SYNC: ready = !rel_pending && cnt_empty;
                OP_ACQ:  ready = !rel_pending;
                OP_REL:  ready = !rel_pending && cnt_empty;
                default: ready = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mem_fence_unit.sv
// Memory operation ordering fence unit (top).
// Does: holds back the head of an in-order issue stream until its ordering
// rule is met. Sync is a full barrier. Acquire and release are one-sided.
// Assumes: memory returns exactly one completion per issued access and
// accepts every issued operation immediately.
module mem_fence_unit
    import fence_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [1:0] op_kind,
    output logic       op_ready,
    output logic       mem_valid,
    output logic [1:0] mem_kind,
    input  logic       cpl_valid,
    input  logic       cpl_sync
);
    op_kind_e         kind;
    logic             issue;
    logic [CNT_W-1:0] cnt;
    logic             cnt_full;
    logic             cnt_empty;
    logic             block_all;
    logic             rel_pending;
    logic             data_issue;
    logic             fence_issue;
    logic             rel_issue;
    logic             data_cpl;
    logic             sync_cpl;

    // Classify this cycle's issue and completion events
    always_comb begin
        kind        = op_kind_e'(op_kind);
        issue       = op_valid && op_ready;
        data_issue  = issue && (kind == OP_DATA);
        fence_issue = issue && ((kind == OP_SYNC) || (kind == OP_ACQ));
        rel_issue   = issue && (kind == OP_REL);
        data_cpl    = cpl_valid && !cpl_sync;
        sync_cpl    = cpl_valid && cpl_sync;
        mem_valid   = issue;
        mem_kind    = op_kind;
    end

    fence_data_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (data_issue),
        .dec   (data_cpl),
        .cnt   (cnt),
        .full  (cnt_full),
        .empty (cnt_empty)
    );

    fence_sync_track u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_issue (fence_issue),
        .rel_issue   (rel_issue),
        .sync_cpl    (sync_cpl),
        .block_all   (block_all),
        .rel_pending (rel_pending)
    );

    fence_issue_gate u_gate (
        .in_reset    (!rst_n),
        .kind        (kind),
        .cnt_full    (cnt_full),
        .cnt_empty   (cnt_empty),
        .block_all   (block_all),
        .rel_pending (rel_pending),
        .ready       (op_ready)
    );

    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && (mem_kind == 2'b01)) |-> (cnt == '0)); // R4
    AST_BLOCK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        block_all |-> !mem_valid); // R5
    AST_REL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && (mem_kind == 2'b11)) |-> (cnt == '0) && !rel_pending); // R7
    AST_REL_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_pending && mem_valid) |-> (mem_kind == 2'b00)); // R8
    AST_FULL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_full |-> !(mem_valid && (mem_kind == 2'b00))); // R3
endmodule

// File: tb/test_mem_fence_unit.sv
module test_mem_fence_unit;
    localparam int CNT_W = 3;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_kind = 2'b00;
    logic       op_ready;
    logic       mem_valid;
    logic [1:0] mem_kind;
    logic       cpl_valid = 1'b0;
    logic       cpl_sync = 1'b0;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    mem_fence_unit #(.CNT_W(CNT_W)) i_mem_fence_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_ready(op_ready), .mem_valid(mem_valid), .mem_kind(mem_kind),
        .cpl_valid(cpl_valid), .cpl_sync(cpl_sync)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected readiness: st 0 idle, 1 sync/acquire pending, 2 release pending
    function automatic bit exp_ready(input int k, input int n, input int st);
        if (st == 1) return 1'b0;
        case (k)
            0: return n < MAXC;
            1: return st == 0 && n == 0;
            2: return st == 0;
            default: return st == 0 && n == 0;
        endcase
    endfunction

    // One clock: drive at the falling edge, clear after the rising edge
    task automatic step(input bit v, input int k, input bit cv, input bit cs);
        @(negedge clk);
        op_valid = v; op_kind = 2'(k); cpl_valid = cv; cpl_sync = cs;
        #1;
        if (v) begin
            chk(mem_valid == op_ready, "R9", mem_valid, op_ready);
            chk(mem_kind == 2'(k), "R9", mem_kind, k);
        end
        @(posedge clk);
        #0.5;
        op_valid = 1'b0; cpl_valid = 1'b0; cpl_sync = 1'b0;
    endtask

    task automatic issue_ok(input int k, input string req);
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'(k);
        #1;
        chk(op_ready && mem_valid, req, mem_valid, 1);
        @(posedge clk);
        #0.5;
        op_valid = 1'b0;
    endtask

    task automatic probe(input int k, input bit exp, input string req);
        @(negedge clk);
        op_valid = 1'b0; op_kind = 2'(k);
        #1;
        chk(op_ready == exp, req, op_ready, exp);
        chk(!mem_valid, "R9", mem_valid, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b1; op_kind = 2'b00;
        #1;
        chk(!op_ready && !mem_valid, "R1", op_ready, 0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; op_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int k = 0; k < 4; k++) probe(k, 1'b1, "R1");

        // R3 R4 R6 R7 R8: sweep count and tracker state, probe every kind
        for (int st = 0; st < 3; st++) begin
            for (int n = 0; n <= MAXC; n++) begin
                do_reset();
                if (st == 2) issue_ok(3, "R7");
                for (int i = 0; i < n; i++) issue_ok(0, (st == 2) ? "R8" : "R2");
                if (st == 1) issue_ok(2, "R6");
                for (int k = 0; k < 4; k++)
                    probe(k, exp_ready(k, n, st), (k == 0) ? "R3" : (k == 1) ? "R4" :
                          (k == 2) ? "R6" : "R7");
            end
        end

        // R5: sync blocks all until its completion; R10 timing of the unblock
        do_reset();
        issue_ok(1, "R4");
        for (int k = 0; k < 4; k++) probe(k, 1'b0, "R5");
        @(negedge clk);
        cpl_valid = 1'b1; cpl_sync = 1'b1; op_kind = 2'b00;
        #1;
        chk(!op_ready, "R10", op_ready, 0);
        @(posedge clk);
        #0.5;
        cpl_valid = 1'b0; cpl_sync = 1'b0;
        #1;
        chk(op_ready, "R10", op_ready, 1);

        // R5: a data completion does not clear a pending acquire
        do_reset();
        issue_ok(0, "R2");
        issue_ok(2, "R6");
        step(1'b0, 0, 1'b1, 1'b0);
        probe(0, 1'b0, "R5");
        step(1'b0, 0, 1'b1, 1'b1);
        probe(0, 1'b1, "R5");
        probe(1, 1'b1, "R2");

        // R2: issue and completion in the same cycle hold the count
        do_reset();
        for (int i = 0; i < 3; i++) issue_ok(0, "R2");
        step(1'b1, 0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b1, 1'b0);
        probe(1, 1'b0, "R2");
        step(1'b0, 0, 1'b1, 1'b0);
        probe(1, 1'b1, "R2");

        // R3: at full, a completion frees one slot
        do_reset();
        for (int i = 0; i < MAXC; i++) issue_ok(0, "R2");
        step(1'b1, 0, 1'b0, 1'b0);
        probe(0, 1'b0, "R3");
        step(1'b0, 0, 1'b1, 1'b0);
        probe(0, 1'b1, "R3");

        // R11: stray completions change nothing
        do_reset();
        step(1'b0, 0, 1'b1, 1'b0);
        probe(0, 1'b1, "R11");
        probe(1, 1'b1, "R11");
        step(1'b0, 0, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++) probe(k, 1'b1, "R11");
        issue_ok(0, "R2");
        probe(1, 1'b0, "R11");

        // R8: release completion unblocks sync-class kinds
        do_reset();
        issue_ok(3, "R7");
        issue_ok(0, "R8");
        step(1'b0, 0, 1'b1, 1'b0);
        probe(2, 1'b0, "R8");
        step(1'b0, 0, 1'b1, 1'b1);
        probe(2, 1'b1, "R8");
        probe(3, 1'b1, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule